// File: doc/BRIEF.md
# Trigger Decision Queue and Spacer

This block sits between the second-level trigger and the broadcast encoder that carries trigger decisions to every front-end board. Decisions come in as a stream of single-cycle strobes. Each strobe carries an accept/reject bit and an event number. They arrive in event order but often in bursts. The block queues them and sends them out one at a time. Consecutive releases are always at least a programmable number of clock cycles apart. The slowest front-end can therefore finish handling one decision before the next one reaches it, and no front-end needs a decision queue of its own.

Accepts and rejects are handled identically. Every event held in a front-end buffer is freed by exactly one decision, so both kinds are queued, spaced and released in strict arrival order. A release is also held back while the downstream encoder reports that it is busy. The spacing is counted in 40 MHz clock cycles. After reset it is 80 cycles (2 us), and a one-cycle configuration write can change it. Status outputs give the queue level, running counts of released accepts and released rejects, and a sticky error flag. The flag records decisions that arrive out of order and decisions that are lost because the queue is full.

Top module: `trig_dec_spacer`

## Requirements
- R1: After reset, out_valid_o, level_o, acc_cnt_o, rej_cnt_o and err_o are all zero and the spacing is 80 cycles. The first queued decision is released without waiting for the spacing.
- R2: Decisions leave in the order they were accepted into the queue, each with its own accept bit and event number. A decision sampled at a rising edge into an empty queue, with the spacing expired and busy low, appears on out_valid_o after the following rising edge.
- R3: Rejects (accept bit 0) are queued and released exactly like accepts (accept bit 1). Each queued decision produces exactly one out_valid_o pulse of one cycle.
- R4: Two out_valid_o pulses are never closer than the spacing in force at the earlier release. When decisions are waiting and busy is low, the next pulse comes exactly that many cycles after the previous one.
- R5: No decision is released in a cycle where bcast_busy_i is high. A waiting decision appears on out_valid_o one cycle after the cycle in which busy is seen low.
- R6: A cycle with gap_wr_i high loads gap_val_i as the spacing. The new value applies from the next release on. A spacing of 0 or 1 allows releases in consecutive cycles.
- R7: A decision that arrives while the queue holds DEPTH (16) entries is dropped and never released, and err_o is set.
- R8: The first decision after reset is expected to carry event number 0. Each later one is expected to carry the previous arrival's number plus 1, modulo 2^EVT_W. A mismatch sets err_o, but the decision is still queued and released.
- R9: err_o stays high once set and is cleared only by reset.
- R10: level_o equals the number of decisions held in the queue.
- R11: acc_cnt_o and rej_cnt_o count the accepts and the rejects that have been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 40 MHz clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Decision strobe |
| in_accept_i | input | 1 | 1 = accept, 0 = reject |
| in_evt_i | input | EVT_W (8) | Event number of the decision |
| gap_wr_i | input | 1 | Load a new spacing value |
| gap_val_i | input | GAP_W (12) | Spacing in clock cycles |
| bcast_busy_i | input | 1 | Downstream encoder is busy |
| out_valid_o | output | 1 | One-cycle release pulse |
| out_accept_o | output | 1 | Accept bit of the released decision |
| out_evt_o | output | EVT_W (8) | Event number of the released decision |
| level_o | output | LVL_W (5) | Entries held in the queue |
| acc_cnt_o | output | CNT_W (16) | Accepts released |
| rej_cnt_o | output | CNT_W (16) | Rejects released |
| err_o | output | 1 | Sticky error: order break or overflow |

## Verification
The bench uses several stimulus patterns, and each one separates a different kind of fault:
- A back-to-back burst of alternating accepts and rejects at the default spacing shows whether order is kept, whether both decision kinds get through, and whether the gap is exact.
- Short bursts at spacings of 5 and 1 show whether a new spacing is picked up, and whether a spacing of 1 gives releases on adjacent cycles.
- A decision held behind a long busy period checks that busy blocks release and that the release follows busy going low after one cycle.
- Overfilling the queue behind busy, and sending a skipped event number after a fresh reset, separate the overflow path from the order-error path and show that the error flag stays set.

// File: rtl/tds_pkg.sv
package tds_pkg;

  // Nominal spacing: 2 us at 40 MHz.
  localparam int unsigned TDS_GAP_NOMINAL = 80;

  // Value loaded into the countdown on a release, so that the next release
  // may happen exactly `gap` cycles later (0 and 1 both mean "no wait").
  function automatic logic [31:0] tds_reload(input logic [31:0] gap);
    return (gap == 32'd0) ? 32'd0 : gap - 32'd1;
  endfunction

endpackage

// File: rtl/tds_queue.sv
module tds_queue #(
  parameter int DW    = 9,
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];
  assign level_o = cnt_q;

  always_comb begin
    wr_d  = do_push ? ptr_inc(wr_q) : wr_q;
    rd_d  = do_pop  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage array: written only on an accepted push, no reset needed.
  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  p_pop_nonempty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  p_level_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tds_gap_timer.sv
module tds_gap_timer
  import tds_pkg::*;
#(
  parameter int GAP_W   = 12,
  parameter int GAP_RST = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [GAP_W-1:0] cfg_val_i,
  input  logic             fire_i,
  output logic             ready_o,
  output logic [GAP_W-1:0] gap_o
);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;
  logic [31:0]      reload;

  assign reload  = tds_reload(32'(gap_q));
  assign ready_o = (cnt_q == '0);
  assign gap_o   = gap_q;

  always_comb begin
    gap_d = cfg_wr_i ? cfg_val_i : gap_q;
    if (fire_i)        cnt_d = reload[GAP_W-1:0];
    else if (!ready_o) cnt_d = cnt_q - 1'b1;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= GAP_W'(GAP_RST);
      cnt_q <= '0;
    end else begin
      gap_q <= gap_d;
      cnt_q <= cnt_d;
    end
  end

  p_fire_when_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> ready_o);

  p_gap_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(gap_q));

endmodule

// File: rtl/tds_tally.sv
module tds_tally #(
  parameter int EVT_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [EVT_W-1:0] in_evt_i,
  input  logic             drop_i,
  input  logic             rel_i,
  input  logic             rel_acc_i,
  output logic [CNT_W-1:0] acc_o,
  output logic [CNT_W-1:0] rej_o,
  output logic             err_o
);

  logic [EVT_W-1:0] exp_q, exp_d;
  logic [CNT_W-1:0] acc_q, acc_d, rej_q, rej_d;
  logic             err_q, err_d;
  logic             bad_in;

  assign bad_in = in_valid_i && ((in_evt_i != exp_q) || drop_i);

  always_comb begin
    exp_d = in_valid_i ? in_evt_i + 1'b1 : exp_q;
    err_d = err_q | bad_in;
    acc_d = (rel_i &&  rel_acc_i) ? acc_q + 1'b1 : acc_q;
    rej_d = (rel_i && !rel_acc_i) ? rej_q + 1'b1 : rej_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      err_q <= 1'b0;
      acc_q <= '0;
      rej_q <= '0;
    end else begin
      exp_q <= exp_d;
      err_q <= err_d;
      acc_q <= acc_d;
      rej_q <= rej_d;
    end
  end

  assign acc_o = acc_q;
  assign rej_o = rej_q;
  assign err_o = err_q;

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);

  p_counts_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rel_i |=> ($stable(acc_q) && $stable(rej_q)));

endmodule

// File: rtl/trig_dec_spacer.sv
module trig_dec_spacer
  import tds_pkg::*;
#(
  parameter int EVT_W   = 8,
  parameter int DEPTH   = 16,
  parameter int GAP_W   = 12,
  parameter int GAP_RST = int'(TDS_GAP_NOMINAL),
  parameter int CNT_W   = 16,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic             in_accept_i,
  input  logic [EVT_W-1:0] in_evt_i,
  input  logic             gap_wr_i,
  input  logic [GAP_W-1:0] gap_val_i,
  input  logic             bcast_busy_i,
  output logic             out_valid_o,
  output logic             out_accept_o,
  output logic [EVT_W-1:0] out_evt_o,
  output logic [LVL_W-1:0] level_o,
  output logic [CNT_W-1:0] acc_cnt_o,
  output logic [CNT_W-1:0] rej_cnt_o,
  output logic             err_o
);

  localparam int DW = EVT_W + 1;

  logic          q_full, q_empty, t_ready, release_c;
  logic [DW-1:0] q_head;
  logic [GAP_W-1:0] gap_cur;

  logic             vld_q, vld_d;
  logic             acc_q, acc_d;
  logic [EVT_W-1:0] evt_q, evt_d;

  assign release_c = !q_empty && t_ready && !bcast_busy_i;

  tds_queue #(.DW(DW), .DEPTH(DEPTH), .CW(LVL_W)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_valid_i),
    .pop_i   (release_c),
    .wdata_i ({in_accept_i, in_evt_i}),
    .rdata_o (q_head),
    .level_o (level_o),
    .full_o  (q_full),
    .empty_o (q_empty)
  );

  tds_gap_timer #(.GAP_W(GAP_W), .GAP_RST(GAP_RST)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_wr_i  (gap_wr_i),
    .cfg_val_i (gap_val_i),
    .fire_i    (release_c),
    .ready_o   (t_ready),
    .gap_o     (gap_cur)
  );

  tds_tally #(.EVT_W(EVT_W), .CNT_W(CNT_W)) u_tally (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_evt_i   (in_evt_i),
    .drop_i     (q_full),
    .rel_i      (release_c),
    .rel_acc_i  (q_head[DW-1]),
    .acc_o      (acc_cnt_o),
    .rej_o      (rej_cnt_o),
    .err_o      (err_o)
  );

  always_comb begin
    vld_d = release_c;
    acc_d = release_c ? q_head[DW-1]      : acc_q;
    evt_d = release_c ? q_head[EVT_W-1:0] : evt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
      evt_q <= '0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
      evt_q <= evt_d;
    end
  end

  assign out_valid_o  = vld_q;
  assign out_accept_o = acc_q;
  assign out_evt_o    = evt_q;

  // ---------------- checking logic for the output spacing ----------------
  localparam int SC_W = GAP_W + 1;
  logic [SC_W-1:0]  since_q;
  logic [GAP_W-1:0] gap_rel_q, gap_prev_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q    <= '1;
      gap_rel_q  <= '0;
      gap_prev_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      if (release_c) gap_rel_q <= gap_cur;
      if (vld_q) begin
        since_q    <= SC_W'(1);
        gap_prev_q <= gap_rel_q;
        seen_q     <= 1'b1;
      end else if (since_q != '1) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  p_min_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && seen_q) |-> (since_q >= SC_W'(gap_prev_q)));

  p_busy_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$past(bcast_busy_i));

  p_full_sets_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && q_full) |=> err_o);

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (gap_prev_q > GAP_W'(1)) && (gap_rel_q > GAP_W'(1))) |=> !out_valid_o);

endmodule

// File: tb/trig_dec_spacer_tb.sv
module trig_dec_spacer_tb_top;

  localparam int CLK_PERIOD = 25;
  localparam int EVT_W = 8;
  localparam int GAP_W = 12;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0, in_acc = 1'b0;
  logic [EVT_W-1:0] in_evt = '0;
  logic             gap_wr = 1'b0;
  logic [GAP_W-1:0] gap_val = '0;
  logic             busy = 1'b0;
  logic             out_valid, out_acc, err;
  logic [EVT_W-1:0] out_evt;
  logic [4:0]       level;
  logic [15:0]      acc_cnt, rej_cnt;

  int checks = 0, fails = 0, cyc = 0;
  int n_log = 0;
  int log_cyc [64];
  int log_evt [64];
  int log_acc [64];
  int nev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_dec_spacer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_accept_i(in_acc), .in_evt_i(in_evt),
    .gap_wr_i(gap_wr), .gap_val_i(gap_val), .bcast_busy_i(busy),
    .out_valid_o(out_valid), .out_accept_o(out_acc), .out_evt_o(out_evt),
    .level_o(level), .acc_cnt_o(acc_cnt), .rej_cnt_o(rej_cnt), .err_o(err)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (out_valid && n_log < 64) begin
      log_cyc[n_log] = cyc;
      log_evt[n_log] = int'(out_evt);
      log_acc[n_log] = int'(out_acc);
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input bit a, input int e);
    in_valid = 1'b1; in_acc = a; in_evt = EVT_W'(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_gap(input int g);
    gap_wr = 1'b1; gap_val = GAP_W'(g);
    @(negedge clk);
    gap_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    nev = 0;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(level == 0, "R1 level", int'(level), 0);
    chk(acc_cnt == 0 && rej_cnt == 0, "R1 counts", int'(acc_cnt) + int'(rej_cnt), 0);
    chk(err == 1'b0, "R1 err", int'(err), 0);
  endtask

  task automatic t_burst_default();
    n_log = 0;
    push(1'b1, 0);
    chk(out_valid == 1'b0, "R2 not yet", int'(out_valid), 0);
    push(1'b0, 1);
    chk(out_valid == 1'b1 && out_evt == 0, "R2 latency", int'(out_valid), 1);
    push(1'b1, 2);
    push(1'b0, 3);
    chk(level == 3, "R10 burst level", int'(level), 3);
    nev = 4;
    idle(4 * 80 + 20);
    chk(n_log == 4, "R3 release count", n_log, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_evt[i] == i, "R2 order", log_evt[i], i);
      chk(log_acc[i] == ((i % 2) == 0 ? 1 : 0), "R3 kind", log_acc[i], (i % 2) == 0 ? 1 : 0);
      if (i > 0) chk(log_cyc[i] - log_cyc[i-1] == 80, "R1 R4 default gap",
                     log_cyc[i] - log_cyc[i-1], 80);
    end
    chk(acc_cnt == 2, "R11 accepts", int'(acc_cnt), 2);
    chk(rej_cnt == 2, "R11 rejects", int'(rej_cnt), 2);
    chk(level == 0, "R10 drained", int'(level), 0);
  endtask

  task automatic t_gap_prog();
    set_gap(5);
    n_log = 0;
    for (int i = 0; i < 3; i++) push(1'b1, nev + i);
    nev += 3;
    idle(30);
    chk(n_log == 3, "R6 count gap5", n_log, 3);
    for (int i = 1; i < 3; i++)
      chk(log_cyc[i] - log_cyc[i-1] == 5, "R6 gap5", log_cyc[i] - log_cyc[i-1], 5);
    set_gap(1);
    n_log = 0;
    for (int i = 0; i < 3; i++) push(1'b0, nev + i);
    nev += 3;
    idle(10);
    chk(n_log == 3, "R6 count gap1", n_log, 3);
    for (int i = 1; i < 3; i++)
      chk(log_cyc[i] - log_cyc[i-1] == 1, "R6 gap1", log_cyc[i] - log_cyc[i-1], 1);
    chk(rej_cnt == 5, "R11 rejects", int'(rej_cnt), 5);
    chk(err == 1'b0, "R8 in order", int'(err), 0);
  endtask

  task automatic t_busy();
    n_log = 0;
    busy = 1'b1;
    push(1'b1, nev);
    nev++;
    for (int i = 0; i < 20; i++) begin
      chk(out_valid == 1'b0, "R5 held", int'(out_valid), 0);
      @(negedge clk);
    end
    chk(level == 1, "R10 held level", int'(level), 1);
    busy = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R5 release after busy", int'(out_valid), 1);
    chk(int'(out_evt) == nev - 1, "R5 event", int'(out_evt), nev - 1);
    idle(3);
  endtask

  task automatic t_full();
    int first;
    first = nev;
    busy = 1'b1;
    for (int i = 0; i < DEPTH + 2; i++) push(1'b1, nev + i);
    nev += DEPTH + 2;
    chk(level == DEPTH, "R7 level full", int'(level), DEPTH);
    chk(err == 1'b1, "R7 overflow err", int'(err), 1);
    n_log = 0;
    busy = 1'b0;
    idle(30);
    chk(n_log == DEPTH, "R7 dropped absent", n_log, DEPTH);
    for (int i = 0; i < DEPTH; i++)
      chk(log_evt[i] == ((first + i) % 256), "R2 order after full", log_evt[i], (first + i) % 256);
    chk(err == 1'b1, "R9 sticky", int'(err), 1);
  endtask

  task automatic t_order();
    do_reset();
    chk(err == 1'b0, "R9 reset clears", int'(err), 0);
    n_log = 0;
    push(1'b1, 0);
    chk(err == 1'b0, "R8 first is 0", int'(err), 0);
    push(1'b0, 5);
    chk(err == 1'b1, "R8 skip flagged", int'(err), 1);
    idle(200);
    chk(n_log == 2, "R8 still released", n_log, 2);
    chk(n_log == 2 && log_evt[1] == 5, "R8 skipped event", log_evt[1], 5);
    chk(n_log == 2 && log_cyc[1] - log_cyc[0] == 80, "R1 gap after reset",
        log_cyc[1] - log_cyc[0], 80);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_burst_default();
    t_gap_prog();
    t_busy();
    t_full();
    t_order();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule